// File: doc/BRIEF.md
# Dual-Clock Interprocessor Mailbox

This block joins two processors that run on unrelated clocks. Each processor owns one side of the block. A side has its own register port, its own reset and one level-high interrupt line. Through the port a side reaches four 32-bit outgoing word slots, four 32-bit incoming word slots, a status word and a control word.

A word placed in outgoing slot n on one side lands in incoming slot n on the other side. Per-slot full and empty flags track the word through its trip and back. Neither side can overwrite a word that the far side has not yet consumed.

Besides the word slots, each side can ring four doorbells on the far side. A rung doorbell shows there as a pending bit, which software clears by writing a one to it. Each side also drives three plain flag bits that the far side reads as status. Every event that crosses between the sides is re-timed into the receiving clock domain.

Top module: `mbox_dual_unit`

## Requirements
- R1: After reset each side's status word (offset 0x20) reads 0x00F00000, meaning every send-empty bit is set. Each control word (offset 0x24) reads 0 and both interrupt lines are low.
- R2: A write to outgoing slot n (offset 4n) while send-empty n (status bit 23-n) is set stores the word and clears send-empty n on the next cycle. The word then appears in the far side's incoming slot n (offset 0x10+4n), and the far side's receive-full n (status bit 27-n) sets.
- R3: A read of incoming slot n while receive-full n is set clears receive-full n. Send-empty n on the sending side then sets after synchronisation. A read while receive-full n is clear changes nothing.
- R4: A write to outgoing slot n while send-empty n is clear is dropped. The slot keeps its earlier word, and the far side receives that earlier word.
- R5: Writing control with bit 19-n at 1 rings doorbell n. Doorbell-pending n (status bit 31-n) on the far side sets. The ringing bit reads back as 1 until the far pending bit has been set, and then clears by itself. Writing 0 to a ringing bit has no effect.
- R6: A status write with bit 31-n at 1 clears doorbell-pending n, and a 0 in that bit leaves it alone. Every other status bit ignores writes.
- R7: Control bits 2:0 hold this side's three flags, and the far side reads them in its status bits 2:0 after synchronisation. The enables read back as written: doorbell enables in control bits 31-n, receive enables in bits 27-n and send enables in bits 23-n.
- R8: A side's interrupt is high exactly when, on that side, (pending n and doorbell enable n), (receive-full n and receive enable n) or (send-empty n and send enable n) holds for some n.
- R9: Outgoing slots read back the word they hold. Any address outside 0x00 to 0x24 reads 0, and writes to such an address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A asynchronous reset, active low |
| wr_a | input | 1 | Side A write strobe |
| rd_a | input | 1 | Side A read strobe (read side effects) |
| addr_a | input | AW | Side A byte address |
| wdata_a | input | DW | Side A write data |
| rdata_a | output | DW | Side A read data, combinational from addr_a |
| irq_a | output | 1 | Side A interrupt, level high |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B asynchronous reset, active low |
| wr_b | input | 1 | Side B write strobe |
| rd_b | input | 1 | Side B read strobe (read side effects) |
| addr_b | input | AW | Side B byte address |
| wdata_b | input | DW | Side B write data |
| rdata_b | output | DW | Side B read data, combinational from addr_b |
| irq_b | output | 1 | Side B interrupt, level high |

## Verification
The assertions assume that no event source on a channel fires again before its previous event has crossed. Under that assumption, each re-timed pulse lasts one receiving-clock cycle. Send-empty and ringing-bit interlocks provide this assumption on their own. The assertions also assume that both resets are asserted together, so neither side ever sees a half-reset partner. The stimulus runs at most one bus operation per side at a time, with an idle cycle between operations, and it compares cross-domain results only after a settling window of twelve slower-clock cycles.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // channels and flags are fixed by the register layout
  localparam int unsigned NCH      = 4;
  localparam int unsigned NFLAG    = 3;
  // field bases inside status/control; channel n sits at base + (NCH-1-n)
  localparam int unsigned PEND_BASE = 28;
  localparam int unsigned FULL_BASE = 24;
  localparam int unsigned EMPT_BASE = 20;
  localparam int unsigned RING_BASE = 16;
  // byte offsets
  localparam int unsigned OUT_OFS  = 0;
  localparam int unsigned IN_OFS   = 16;
  localparam int unsigned STAT_OFS = 32;
  localparam int unsigned CTRL_OFS = 36;

  function automatic int unsigned ch_bit(input int unsigned base, input int unsigned n);
    return base + (NCH - 1) - n;
  endfunction

  function automatic int unsigned slot_ofs(input int unsigned base, input int unsigned n);
    return base + 4 * n;
  endfunction
endpackage

// File: rtl/mbox_pulse_xing.sv
module mbox_pulse_xing #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_pulse,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_pulse
);
  logic [W-1:0] tog_q;
  logic [W-1:0] sync_q [STAGES+1];

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog_q <= '0;
    else            tog_q <= tog_q ^ src_pulse;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      for (int s = 0; s <= STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= tog_q;
      for (int s = 1; s <= STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign dst_pulse = sync_q[STAGES] ^ sync_q[STAGES-1];

  // R2
  pulse_single_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (dst_pulse != '0) |=> ((dst_pulse & $past(dst_pulse)) == '0));
endmodule

// File: rtl/mbox_bus_sync.sv
module mbox_bus_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '0;
    end else begin
      st_q[0] <= d;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/mbox_side.sv
module mbox_side
  import mbox_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    irq,
  output logic [NCH-1:0][DW-1:0]  tx_word_o,
  output logic [NCH-1:0]          send_o,
  input  logic [NCH-1:0][DW-1:0]  rx_word_i,
  input  logic [NCH-1:0]          deliver_i,
  output logic [NCH-1:0]          rdack_o,
  input  logic [NCH-1:0]          rdack_i,
  output logic [NCH-1:0]          gpreq_o,
  input  logic [NCH-1:0]          gpreq_i,
  output logic [NCH-1:0]          gpack_o,
  input  logic [NCH-1:0]          gpack_i,
  output logic [NFLAG-1:0]        flag_o,
  input  logic [NFLAG-1:0]        flag_i
);
  localparam int BW = $clog2(DW);

  logic [NCH-1:0][DW-1:0] tx_q, rx_q;
  logic [NCH-1:0] te_q, rf_q, gip_q, gir_q, gie_q, rie_q, tie_q;
  logic [NFLAG-1:0] flag_q;

  // named internal events
  logic [NCH-1:0] tx_hit, rx_hit, tx_load, rx_take, gp_fire, gip_w1c;
  logic           sr_hit, cr_hit;
  logic [DW-1:0]  sr_word, cr_word;

  always_comb begin
    sr_hit  = addr == AW'(STAT_OFS);
    cr_hit  = addr == AW'(CTRL_OFS);
    sr_word = '0;
    cr_word = '0;
    sr_word[NFLAG-1:0] = flag_i;
    cr_word[NFLAG-1:0] = flag_q;
    for (int n = 0; n < NCH; n++) begin
      tx_hit[n]  = addr == AW'(slot_ofs(OUT_OFS, n));
      rx_hit[n]  = addr == AW'(slot_ofs(IN_OFS, n));
      tx_load[n] = wr_en && tx_hit[n] && te_q[n];
      rx_take[n] = rd_en && rx_hit[n] && rf_q[n];
      gp_fire[n] = wr_en && cr_hit && wdata[BW'(ch_bit(RING_BASE, n))] && !gir_q[n];
      gip_w1c[n] = wr_en && sr_hit && wdata[BW'(ch_bit(PEND_BASE, n))];
      sr_word[BW'(ch_bit(PEND_BASE, n))] = gip_q[n];
      sr_word[BW'(ch_bit(FULL_BASE, n))] = rf_q[n];
      sr_word[BW'(ch_bit(EMPT_BASE, n))] = te_q[n];
      cr_word[BW'(ch_bit(PEND_BASE, n))] = gie_q[n];
      cr_word[BW'(ch_bit(FULL_BASE, n))] = rie_q[n];
      cr_word[BW'(ch_bit(EMPT_BASE, n))] = tie_q[n];
      cr_word[BW'(ch_bit(RING_BASE, n))] = gir_q[n];
    end
  end

  always_comb begin
    rdata = '0;
    if (sr_hit) rdata = sr_word;
    if (cr_hit) rdata = cr_word;
    for (int n = 0; n < NCH; n++) begin
      if (tx_hit[n]) rdata = tx_q[n];
      if (rx_hit[n]) rdata = rx_q[n];
    end
  end

  assign irq = |(gip_q & gie_q) | |(rf_q & rie_q) | |(te_q & tie_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      te_q   <= '1;
      rf_q   <= '0;
      gip_q  <= '0;
      gir_q  <= '0;
      gie_q  <= '0;
      rie_q  <= '0;
      tie_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && cr_hit) begin
        flag_q <= wdata[NFLAG-1:0];
        for (int n = 0; n < NCH; n++) begin
          gie_q[n] <= wdata[BW'(ch_bit(PEND_BASE, n))];
          rie_q[n] <= wdata[BW'(ch_bit(FULL_BASE, n))];
          tie_q[n] <= wdata[BW'(ch_bit(EMPT_BASE, n))];
        end
      end
      for (int n = 0; n < NCH; n++) begin
        if (tx_load[n]) begin
          tx_q[n] <= wdata;
          te_q[n] <= 1'b0;
        end else if (rdack_i[n]) begin
          te_q[n] <= 1'b1;
        end
        if (deliver_i[n]) begin
          rx_q[n] <= rx_word_i[n];
          rf_q[n] <= 1'b1;
        end else if (rx_take[n]) begin
          rf_q[n] <= 1'b0;
        end
        if (gpreq_i[n])      gip_q[n] <= 1'b1;
        else if (gip_w1c[n]) gip_q[n] <= 1'b0;
        if (gp_fire[n])      gir_q[n] <= 1'b1;
        else if (gpack_i[n]) gir_q[n] <= 1'b0;
      end
    end
  end

  assign tx_word_o = tx_q;
  assign send_o    = tx_load;
  assign rdack_o   = rx_take;
  assign gpreq_o   = gp_fire;
  assign gpack_o   = gpreq_i;
  assign flag_o    = flag_q;

  for (genvar gn = 0; gn < NCH; gn++) begin : g_chk
    // R2
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load[gn] |=> !te_q[gn]);
    // R4
    tx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tx_hit[gn] && !te_q[gn]) |=> $stable(tx_q[gn]));
    // R3
    rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_take[gn] && !deliver_i[gn]) |=> !rf_q[gn]);
    // R6
    gip_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gip_w1c[gn] && !gpreq_i[gn]) |=> !gip_q[gn]);
    // R6
    gip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gip_q[gn] && !gip_w1c[gn]) |=> gip_q[gn]);
    // R5
    gir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gir_q[gn] && !gpack_i[gn]) |=> gir_q[gn]);
  end
endmodule

// File: rtl/mbox_dual_unit.sv
module mbox_dual_unit
  import mbox_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_a,
  input  logic          rst_a_n,
  input  logic          wr_a,
  input  logic          rd_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdata_a,
  output logic [DW-1:0] rdata_a,
  output logic          irq_a,
  input  logic          clk_b,
  input  logic          rst_b_n,
  input  logic          wr_b,
  input  logic          rd_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rdata_b,
  output logic          irq_b
);
  logic [NCH-1:0] send [2], deliver [2], rdack [2], txfree [2];
  logic [NCH-1:0] gpreq [2], gppend [2], gpack [2], gpdone [2];
  logic [NCH-1:0][DW-1:0] txw [2];
  logic [NFLAG-1:0] flg [2], flg_seen [2];
  logic [DW-1:0] rd_v [2];
  logic irq_v [2];
  logic clk_v [2];
  logic rst_v [2];

  assign clk_v[0] = clk_a;
  assign clk_v[1] = clk_b;
  assign rst_v[0] = rst_a_n;
  assign rst_v[1] = rst_b_n;

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int O = 1 - s;

    mbox_side #(.DW(DW), .AW(AW)) u_side (
      .clk       (clk_v[s]),
      .rst_n     (rst_v[s]),
      .wr_en     (s == 0 ? wr_a    : wr_b),
      .rd_en     (s == 0 ? rd_a    : rd_b),
      .addr      (s == 0 ? addr_a  : addr_b),
      .wdata     (s == 0 ? wdata_a : wdata_b),
      .rdata     (rd_v[s]),
      .irq       (irq_v[s]),
      .tx_word_o (txw[s]),
      .send_o    (send[s]),
      .rx_word_i (txw[O]),
      .deliver_i (deliver[s]),
      .rdack_o   (rdack[s]),
      .rdack_i   (txfree[s]),
      .gpreq_o   (gpreq[s]),
      .gpreq_i   (gppend[s]),
      .gpack_o   (gpack[s]),
      .gpack_i   (gpdone[s]),
      .flag_o    (flg[s]),
      .flag_i    (flg_seen[s])
    );

    mbox_pulse_xing #(.W(NCH), .STAGES(SYNC_STAGES)) u_word (
      .src_clk(clk_v[s]), .src_rst_n(rst_v[s]), .src_pulse(send[s]),
      .dst_clk(clk_v[O]), .dst_rst_n(rst_v[O]), .dst_pulse(deliver[O]));

    mbox_pulse_xing #(.W(NCH), .STAGES(SYNC_STAGES)) u_free (
      .src_clk(clk_v[s]), .src_rst_n(rst_v[s]), .src_pulse(rdack[s]),
      .dst_clk(clk_v[O]), .dst_rst_n(rst_v[O]), .dst_pulse(txfree[O]));

    mbox_pulse_xing #(.W(NCH), .STAGES(SYNC_STAGES)) u_ring (
      .src_clk(clk_v[s]), .src_rst_n(rst_v[s]), .src_pulse(gpreq[s]),
      .dst_clk(clk_v[O]), .dst_rst_n(rst_v[O]), .dst_pulse(gppend[O]));

    mbox_pulse_xing #(.W(NCH), .STAGES(SYNC_STAGES)) u_rack (
      .src_clk(clk_v[s]), .src_rst_n(rst_v[s]), .src_pulse(gpack[s]),
      .dst_clk(clk_v[O]), .dst_rst_n(rst_v[O]), .dst_pulse(gpdone[O]));

    mbox_bus_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_flag (
      .dst_clk(clk_v[O]), .dst_rst_n(rst_v[O]), .d(flg[s]), .q(flg_seen[O]));
  end

  assign rdata_a = rd_v[0];
  assign rdata_b = rd_v[1];
  assign irq_a   = irq_v[0];
  assign irq_b   = irq_v[1];
endmodule

// File: tb/mbox_dual_unit_tb_top.sv
module mbox_dual_unit_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = CLK_PERIOD * 8 / 5;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic wr_a = 1'b0, rd_a = 1'b0, wr_b = 1'b0, rd_b = 1'b0;
  logic [5:0]  addr_a = '0, addr_b = '0;
  logic [31:0] wdata_a = '0, wdata_b = '0;
  logic [31:0] rdata_a, rdata_b;
  logic irq_a, irq_b;

  always #(CLK_PERIOD/2)   clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  mbox_dual_unit dut_i (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .wr_a(wr_a), .rd_a(rd_a), .addr_a(addr_a),
    .wdata_a(wdata_a), .rdata_a(rdata_a), .irq_a(irq_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .wr_b(wr_b), .rd_b(rd_b), .addr_b(addr_b),
    .wdata_b(wdata_b), .rdata_b(rdata_b), .irq_b(irq_b));

  // behavioural reference model, index [side][channel]
  bit m_te [2][4], m_rf [2][4], m_gip [2][4];
  bit m_gie [2][4], m_rie [2][4], m_tie [2][4];
  logic [31:0] m_rx [2][4], m_tx [2][4];
  logic [2:0] m_flg [2];
  int checks = 0, fails = 0;
  bit settled = 0, finished = 0;

  function automatic logic [31:0] exp_sr(int s);
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[31-n] = m_gip[s][n];
      v[27-n] = m_rf[s][n];
      v[23-n] = m_te[s][n];
    end
    v[2:0] = m_flg[1-s];
    return v;
  endfunction

  function automatic logic [31:0] exp_cr(int s);
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[31-n] = m_gie[s][n];
      v[27-n] = m_rie[s][n];
      v[23-n] = m_tie[s][n];
    end
    v[2:0] = m_flg[s];
    return v;
  endfunction

  function automatic bit exp_irq(int s);
    bit r = 0;
    for (int n = 0; n < 4; n++)
      r = r | (m_gip[s][n] & m_gie[s][n]) | (m_rf[s][n] & m_rie[s][n]) | (m_te[s][n] & m_tie[s][n]);
    return r;
  endfunction

  task automatic expect_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int s, logic [5:0] a, logic [31:0] d);
    settled = 0;
    if (s == 0) begin
      @(negedge clk_a); wr_a = 1; addr_a = a; wdata_a = d;
      @(negedge clk_a); wr_a = 0;
    end else begin
      @(negedge clk_b); wr_b = 1; addr_b = a; wdata_b = d;
      @(negedge clk_b); wr_b = 0;
    end
  endtask

  task automatic bus_rd(int s, logic [5:0] a, output logic [31:0] d);
    settled = 0;
    if (s == 0) begin
      @(negedge clk_a); rd_a = 1; addr_a = a; #1 d = rdata_a;
      @(negedge clk_a); rd_a = 0;
    end else begin
      @(negedge clk_b); rd_b = 1; addr_b = a; #1 d = rdata_b;
      @(negedge clk_b); rd_b = 0;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk_b);
    settled = 1;
  endtask

  task automatic chk_reg(int s, logic [5:0] a, logic [31:0] exp, string tag);
    logic [31:0] r;
    bus_rd(s, a, r);
    expect_val(tag, r, exp);
  endtask

  task automatic chk_irq(int s, string tag);
    expect_val(tag, {31'b0, (s == 0) ? irq_a : irq_b}, {31'b0, exp_irq(s)});
  endtask

  // send a word; immediately checks the local send-empty bits
  task automatic send(int s, int n, logic [31:0] d, string tag);
    logic [31:0] r;
    bus_wr(s, 6'(4*n), d);
    if (m_te[s][n]) begin
      m_te[s][n] = 0; m_tx[s][n] = d;
      m_rf[1-s][n] = 1; m_rx[1-s][n] = d;
    end
    bus_rd(s, 6'h20, r);
    expect_val(tag, r & 32'h00F0_0000, exp_sr(s) & 32'h00F0_0000);
  endtask

  task automatic take(int s, int n, string tag);
    logic [31:0] r;
    bus_rd(s, 6'(16 + 4*n), r);
    expect_val(tag, r, m_rx[s][n]);
    if (m_rf[s][n]) begin
      m_rf[s][n] = 0;
      m_te[1-s][n] = 1;
    end
  endtask

  task automatic cr_wr(int s, logic [3:0] gie, logic [3:0] rie, logic [3:0] tie,
                       logic [3:0] ring, logic [2:0] flags);
    logic [31:0] v = '0;
    for (int n = 0; n < 4; n++) begin
      v[31-n] = gie[n]; v[27-n] = rie[n]; v[23-n] = tie[n]; v[19-n] = ring[n];
      m_gie[s][n] = gie[n]; m_rie[s][n] = rie[n]; m_tie[s][n] = tie[n];
      if (ring[n]) m_gip[1-s][n] = 1;
    end
    v[2:0] = flags;
    m_flg[s] = flags;
    bus_wr(s, 6'h24, v);
  endtask

  task automatic sr_wr(int s, logic [31:0] d);
    bus_wr(s, 6'h20, d);
    for (int n = 0; n < 4; n++) if (d[31-n]) m_gip[s][n] = 0;
  endtask

  // R8: per-clock comparison of interrupt lines against the model
  always @(negedge clk_a) if (settled && !finished) begin
    checks++;
    if (irq_a !== exp_irq(0)) begin
      fails++;
      $display("FAIL R8 irq_a per-clock: actual %b expected %b", irq_a, exp_irq(0));
    end
  end
  always @(negedge clk_b) if (settled && !finished) begin
    checks++;
    if (irq_b !== exp_irq(1)) begin
      fails++;
      $display("FAIL R8 irq_b per-clock: actual %b expected %b", irq_b, exp_irq(1));
    end
  end

  initial begin
    repeat (100000) @(posedge clk_a);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int s = 0; s < 2; s++) begin
      m_flg[s] = '0;
      for (int n = 0; n < 4; n++) begin
        m_te[s][n] = 1; m_rf[s][n] = 0; m_gip[s][n] = 0;
        m_gie[s][n] = 0; m_rie[s][n] = 0; m_tie[s][n] = 0;
        m_rx[s][n] = '0; m_tx[s][n] = '0;
      end
    end
    repeat (5) @(negedge clk_b);
    rst_a_n = 1; rst_b_n = 1;
    settle();

    // R1 reset state
    chk_reg(0, 6'h20, 32'h00F0_0000, "R1 status A");
    chk_reg(1, 6'h20, 32'h00F0_0000, "R1 status B");
    chk_reg(0, 6'h24, 32'h0, "R1 control A");
    chk_reg(1, 6'h24, 32'h0, "R1 control B");
    expect_val("R1 irq A", {31'b0, irq_a}, 32'h0);
    expect_val("R1 irq B", {31'b0, irq_b}, 32'h0);

    // R2 four words A to B
    for (int n = 0; n < 4; n++) send(0, n, 32'hA5C0_0000 + 32'(n * 32'h1111), "R2 send-empty clear A");
    settle();
    chk_reg(1, 6'h20, exp_sr(1), "R2 receive-full at B");
    chk_reg(1, 6'h20, 32'h0FF0_0000, "R2 status B literal");

    // R4 write while busy is dropped
    send(0, 1, 32'hDEAD_BEEF, "R4 busy write keeps flags");
    chk_reg(0, 6'h04, m_tx[0][1], "R4 outgoing slot kept");
    settle();
    chk_reg(1, 6'h20, exp_sr(1), "R4 far status unchanged");

    // R3 consume, full clears, empty returns
    take(1, 0, "R3 data ch0 at B");
    chk_reg(1, 6'h20, exp_sr(1), "R3 full clear ch0");
    take(1, 1, "R4 data ch1 is first word");
    take(1, 1, "R3 read of empty slot");
    chk_reg(1, 6'h20, exp_sr(1), "R3 empty read no effect");
    settle();
    chk_reg(0, 6'h20, exp_sr(0), "R3 send-empty back at A");

    // reverse direction
    send(1, 2, 32'h1234_5678, "R2 send-empty clear B");
    settle();
    chk_reg(0, 6'h20, exp_sr(0), "R2 receive-full at A");
    take(0, 2, "R2 data ch2 at A");
    settle();
    chk_reg(1, 6'h20, exp_sr(1), "R3 send-empty back at B");

    // R5 doorbell
    cr_wr(0, 4'b0, 4'b0, 4'b0, 4'b0100, 3'b000);
    chk_reg(0, 6'h24, 32'h0002_0000, "R5 ring bit held");
    settle();
    chk_reg(1, 6'h20, exp_sr(1), "R5 pending at B");
    chk_reg(0, 6'h24, exp_cr(0), "R5 ring bit self-clear");

    // R6 write-one-to-clear
    sr_wr(1, 32'h0);
    chk_reg(1, 6'h20, exp_sr(1), "R6 zero write keeps pending");
    sr_wr(1, 32'h0FF0_0007);
    chk_reg(1, 6'h20, exp_sr(1), "R6 other status bits ignore writes");
    sr_wr(1, 32'h2000_0000);
    chk_reg(1, 6'h20, exp_sr(1), "R6 pending cleared");

    // R7 flags and control readback
    cr_wr(0, 4'b1001, 4'b0110, 4'b0000, 4'b0, 3'b101);
    chk_reg(0, 6'h24, exp_cr(0), "R7 control readback A");
    cr_wr(1, 4'b0, 4'b0, 4'b0, 4'b0, 3'b010);
    settle();
    chk_reg(1, 6'h20, exp_sr(1), "R7 flags seen at B");
    chk_reg(0, 6'h20, exp_sr(0), "R7 flags seen at A");
    cr_wr(0, 4'b0, 4'b0, 4'b0, 4'b0, 3'b101);

    // R8 interrupt combinations
    cr_wr(1, 4'b0, 4'b1000, 4'b0, 4'b0, 3'b010);
    settle();
    chk_irq(1, "R8 receive irq B");
    take(1, 3, "R2 data ch3 at B");
    settle();
    chk_irq(1, "R8 receive irq B dropped");
    cr_wr(0, 4'b0, 4'b0, 4'b0001, 4'b0, 3'b101);
    settle();
    chk_irq(0, "R8 send-empty irq A");
    cr_wr(0, 4'b0010, 4'b0, 4'b0, 4'b0, 3'b101);
    cr_wr(1, 4'b0, 4'b1000, 4'b0, 4'b0010, 3'b010);
    settle();
    chk_irq(0, "R8 doorbell irq A");
    sr_wr(0, 32'h4000_0000);
    settle();
    chk_irq(0, "R8 doorbell irq A cleared");

    // R9 map
    chk_reg(0, 6'h28, 32'h0, "R9 unmapped read A");
    bus_wr(1, 6'h3C, 32'hFFFF_FFFF);
    chk_reg(1, 6'h3C, 32'h0, "R9 unmapped write B");
    chk_reg(1, 6'h20, exp_sr(1), "R9 unmapped write no effect");
    chk_reg(1, 6'h08, m_tx[1][2], "R9 outgoing readback B");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule